// File: doc/BRIEF.md
# Receive Path Sleep and Mute Controller

This block decides whether the receive equalizer of a serial video port that can act as either an input or an output is powered, and whether the received data reaching the core is forced to zero. It takes a two-bit sleep policy, a mute bit, an active-low carrier indication from the analog signal detector and the transmit-enable pin. From these it drives an equalizer power enable, a gated copy of the received data word, the cable driver power enable, and a carrier status bit that software can read.

Three sleep policies exist. With "never sleep" the equalizer is always powered. With "forced sleep" it is always off. With "automatic" it stays on while a carrier is seen and turns off once the carrier has been missing for a programmable number of clock cycles. The carrier input is asynchronous and goes through a synchroniser before use. A sleeping equalizer overrides mute: it stays off whatever mute says, and its output is zero.

The received data path is a plain combinational gate with no handshake. It has no valid/ready pair, holds no storage and cannot apply back-pressure, so the downstream consumer samples the word in the same cycle it appears.

Top module: `rx_sleep_mute_ctrl`

## Requirements
- R1: After reset the registered sleep policy is automatic and the registered mute is 0, whatever values the inputs hold during reset.
- R2: Sleep policy code 2'b00, and also 2'b11, keeps `eq_pwr_en` at 1 regardless of the carrier.
- R3: Sleep policy code 2'b10 keeps `eq_pwr_en` at 0 regardless of the carrier.
- R4: Under policy code 2'b01 (automatic), `eq_pwr_en` falls exactly PD_CYCLES+2 clock edges after `carrier_n` rises and stays high, and stays on before that.
- R5: Under automatic policy, `eq_pwr_en` rises two clock edges after `carrier_n` falls. Any return of the carrier restarts the power-down count from zero.
- R6: `carrier_n` is active low (0 means a signal is present). `carrier_ok` is 1 when a signal is present, with a latency of two clock edges and regardless of the sleep policy.
- R7: With the registered mute at 1, `rx_data_o` is all zero. With mute at 0 and the equalizer powered, `rx_data_o` equals `rx_data_i` in the same cycle.
- R8: Sleep takes precedence over mute. While `eq_pwr_en` is 0, `rx_data_o` is zero, and mute never changes `eq_pwr_en`.
- R9: `tx_drv_en` equals `tx_en` combinationally. A 1 powers the cable driver and a 0 turns it off.
- R10: `sleep_mode` and `mute` are registered, so a change takes effect at the first clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_mode | input | 2 | Sleep policy: 00/11 never, 01 automatic, 10 forced |
| mute | input | 1 | 1 forces the received data to zero |
| carrier_n | input | 1 | Asynchronous carrier indication, low when a signal is present |
| tx_en | input | 1 | Transmit driver enable pin level |
| rx_data_i | input | DW | Received data word from the equalizer |
| eq_pwr_en | output | 1 | Equalizer power enable |
| rx_data_o | output | DW | Gated received data word |
| tx_drv_en | output | 1 | Cable driver power enable |
| carrier_ok | output | 1 | Synchronised carrier status, 1 when a signal is present |

## Verification
The results arrive on different schedules. Policy and mute changes show after one edge. Carrier arrival shows on `carrier_ok` and, under automatic policy, on `eq_pwr_en` after two edges. Carrier loss turns the equalizer off after PD_CYCLES+2 edges. The data gate and `tx_drv_en` follow their inputs in the same cycle. The bench drives every input at the falling edge and compares all outputs one time unit later, against a cycle model that it advances at each rising edge. Directed runs count edges from a carrier change until `eq_pwr_en` moves and compare the count with those latencies.

// File: rtl/rxpc_pkg.sv
package rxpc_pkg;
  typedef enum logic [1:0] {
    SLP_NEVER     = 2'b00,
    SLP_AUTO      = 2'b01,
    SLP_FORCE     = 2'b10,
    SLP_NEVER_ALT = 2'b11
  } sleep_mode_e;
endpackage

// File: rtl/rxpc_sync.sv
module rxpc_sync #(
  parameter int  STAGES    = 2,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= RST_VAL;
        else if (i == 0) chain_q[i] <= async_i;
        else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rxpc_loss_timer.sv
module rxpc_loss_timer #(
  parameter int PD_CYCLES = 16000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic present_i,
  output logic expired_o
);
  localparam int CW = $clog2(PD_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(PD_CYCLES);

  logic [CW-1:0] cnt_q;

  // Restarts on every carrier return; saturates at the limit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (present_i)    cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == LIMIT);
endmodule

// File: rtl/rxpc_policy.sv
module rxpc_policy
  import rxpc_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    sleep_mode_i,
  input  logic          mute_i,
  input  logic          present_i,
  input  logic          expired_i,
  input  logic [DW-1:0] data_i,
  output logic          eq_pwr_o,
  output logic [DW-1:0] data_o,
  output logic [1:0]    mode_o
);
  sleep_mode_e mode_q;
  logic        mute_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SLP_AUTO;
      mute_q <= 1'b0;
    end else begin
      mode_q <= sleep_mode_e'(sleep_mode_i);
      mute_q <= mute_i;
    end
  end

  always_comb begin
    unique case (mode_q)
      SLP_FORCE: eq_pwr_o = 1'b0;
      SLP_AUTO:  eq_pwr_o = present_i | ~expired_i;
      default:   eq_pwr_o = 1'b1;
    endcase
  end

  // Sleep wins over mute: an unpowered path always reads zero.
  assign data_o = (eq_pwr_o && !mute_q) ? data_i : '0;
  assign mode_o = mode_q;
endmodule

// File: rtl/rx_sleep_mute_ctrl.sv
module rx_sleep_mute_ctrl #(
  parameter int DW        = 10,
  parameter int PD_CYCLES = 16000,
  parameter int SYNC_STG  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    sleep_mode,
  input  logic          mute,
  input  logic          carrier_n,
  input  logic          tx_en,
  input  logic [DW-1:0] rx_data_i,
  output logic          eq_pwr_en,
  output logic [DW-1:0] rx_data_o,
  output logic          tx_drv_en,
  output logic          carrier_ok
);
  logic       loss_sync;
  logic       present;
  logic       expired;
  logic [1:0] cur_mode;

  rxpc_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(carrier_n), .sync_o(loss_sync)
  );

  assign present = ~loss_sync;

  rxpc_loss_timer #(.PD_CYCLES(PD_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .present_i(present), .expired_o(expired)
  );

  rxpc_policy #(.DW(DW)) u_policy (
    .clk(clk), .rst_n(rst_n), .sleep_mode_i(sleep_mode), .mute_i(mute),
    .present_i(present), .expired_i(expired), .data_i(rx_data_i),
    .eq_pwr_o(eq_pwr_en), .data_o(rx_data_o), .mode_o(cur_mode)
  );

  assign tx_drv_en  = tx_en;
  assign carrier_ok = present;
endmodule

// File: rtl/rx_sleep_mute_ctrl_chk.sv
module rx_sleep_mute_ctrl_chk #(
  parameter int DW        = 10,
  parameter int PD_CYCLES = 16000
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    sleep_mode,
  input logic          mute,
  input logic          tx_en,
  input logic          eq_pwr_en,
  input logic [DW-1:0] rx_data_o,
  input logic          tx_drv_en,
  input logic          carrier_ok,
  input logic [1:0]    cur_mode
);
  localparam int CW = $clog2(PD_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(PD_CYCLES);

  logic [CW-1:0] lost_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               lost_cnt <= '0;
    else if (carrier_ok)      lost_cnt <= '0;
    else if (lost_cnt != LIMIT) lost_cnt <= lost_cnt + 1'b1;
  end

  assert_never_sleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_mode == 2'b00 || sleep_mode == 2'b11) |=> eq_pwr_en);

  assert_forced_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_mode == 2'b10) |=> !eq_pwr_en);

  assert_loss_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 2'b01 && !carrier_ok && lost_cnt == LIMIT) |-> !eq_pwr_en);

  assert_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 2'b01 && carrier_ok) |-> eq_pwr_en);

  assert_mute_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mute |=> (rx_data_o == '0));

  assert_sleep_over_mute_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !eq_pwr_en |-> (rx_data_o == '0));

  assert_tx_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drv_en == tx_en);
endmodule

bind rx_sleep_mute_ctrl rx_sleep_mute_ctrl_chk #(.DW(DW), .PD_CYCLES(PD_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_mode(sleep_mode), .mute(mute), .tx_en(tx_en),
  .eq_pwr_en(eq_pwr_en), .rx_data_o(rx_data_o), .tx_drv_en(tx_drv_en),
  .carrier_ok(carrier_ok), .cur_mode(cur_mode)
);

// File: tb/tb_rx_sleep_mute_ctrl.sv
module tb_rx_sleep_mute_ctrl;
  localparam int DW = 10;
  localparam int PD = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    sleep_mode = 2'b01;
  logic          mute = 1'b0;
  logic          carrier_n = 1'b1;
  logic          tx_en = 1'b1;
  logic [DW-1:0] rx_data_i = '0;
  logic          eq_pwr_en;
  logic [DW-1:0] rx_data_o;
  logic          tx_drv_en;
  logic          carrier_ok;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_sleep_mute_ctrl #(.DW(DW), .PD_CYCLES(PD)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_mode(sleep_mode), .mute(mute),
    .carrier_n(carrier_n), .tx_en(tx_en), .rx_data_i(rx_data_i),
    .eq_pwr_en(eq_pwr_en), .rx_data_o(rx_data_o), .tx_drv_en(tx_drv_en),
    .carrier_ok(carrier_ok)
  );

  // Cycle model built from the requirements.
  logic       m_s1, m_s2;
  int         m_cnt;
  logic [1:0] m_mode;
  logic       m_mute;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 1'b1; m_s2 <= 1'b1; m_cnt <= 0; m_mode <= 2'b01; m_mute <= 1'b0;
    end else begin
      m_s1 <= carrier_n;
      m_s2 <= m_s1;
      m_cnt <= (!m_s2) ? 0 : ((m_cnt == PD) ? PD : m_cnt + 1);
      m_mode <= sleep_mode;
      m_mute <= mute;
    end
  end

  function automatic logic exp_pwr(logic [1:0] md, logic loss, int cnt);
    if (md == 2'b10) return 1'b0;
    if (md == 2'b01) return (!loss) || (cnt != PD);
    return 1'b1;
  endfunction

  function automatic logic [DW-1:0] exp_data(logic pwr, logic mt, logic [DW-1:0] d);
    return (pwr && !mt) ? d : '0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic p;
    string rq;
    p = exp_pwr(m_mode, m_s2, m_cnt);
    if (m_mode == 2'b10) rq = "R3";
    else if (m_mode == 2'b01) rq = m_s2 ? "R4" : "R5";
    else rq = "R2";
    check(rq, 32'(eq_pwr_en), 32'(p));
    check(p ? "R7" : "R8", 32'(rx_data_o), 32'(exp_data(p, m_mute, rx_data_i)));
    check("R6", 32'(carrier_ok), 32'(!m_s2));
    check("R9", 32'(tx_drv_en), 32'(tx_en));
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    int edges;
    int run;
    void'($urandom(32'h5eed_0387));
    // R1: inputs hold non-default values during reset.
    sleep_mode = 2'b10; mute = 1'b1; carrier_n = 1'b1; rx_data_i = 10'h2A5;
    repeat (3) step();
    rst_n = 1'b1;
    #1;
    check("R1", 32'(eq_pwr_en), 32'd1);
    check("R1", 32'(rx_data_o), 32'h2A5);
    check("R6", 32'(carrier_ok), 32'd0);
    // R10: forced policy and mute take effect at the first edge.
    step(); #1;
    check("R10", 32'(eq_pwr_en), 32'd0);
    check("R8", 32'(rx_data_o), 32'd0);

    // R4 / R5 directed latency measurement under automatic policy.
    sleep_mode = 2'b01; mute = 1'b0; carrier_n = 1'b0;
    repeat (PD + 6) step();
    #1;
    check("R5", 32'(eq_pwr_en), 32'd1);
    step(); carrier_n = 1'b1; edges = 0;
    while (eq_pwr_en && edges < PD + 10) begin
      @(posedge clk); edges++; #1;
    end
    check("R4", 32'(edges), 32'(PD + 2));
    step(); carrier_n = 1'b0; edges = 0;
    while (!eq_pwr_en && edges < 10) begin
      @(posedge clk); edges++; #1;
    end
    check("R5", 32'(edges), 32'd2);
    // R5 restart: loss shorter than the limit, twice in a row, keeps power on.
    for (int k = 0; k < 2; k++) begin
      step(); carrier_n = 1'b1;
      repeat (PD - 1) step();
      carrier_n = 1'b0; #1;
      check("R5", 32'(eq_pwr_en), 32'd1);
    end
    repeat (4) step();
    // R2: code 11 behaves as never sleep even after long loss.
    sleep_mode = 2'b11; carrier_n = 1'b1;
    repeat (PD + 5) step();
    #1;
    check("R2", 32'(eq_pwr_en), 32'd1);

    // Constrained random phase with model comparison every cycle.
    run = 0;
    for (int i = 0; i < 4000; i++) begin
      step();
      if (run == 0) begin
        carrier_n = ~carrier_n;
        run = 1 + ($urandom % (2 * PD + 4));
      end
      run--;
      if ($urandom % 40 == 0) sleep_mode = 2'($urandom);
      if ($urandom % 8 == 0) mute = ~mute;
      tx_en = 1'($urandom);
      rx_data_i = DW'($urandom);
      #1;
      check_all();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule